// File: doc/BRIEF.md
# Segmented Virtually-Tagged Instruction Cache

This block is a read-only instruction cache that sits between a fetch unit and a slower memory port. It works on the already-translated (modified) virtual address. The store is split into segments, and address bits [7:5] pick the segment. Inside a segment every line may hold any tag, so a lookup compares the fetch tag against all lines of that segment at once. A hit returns the stored word without touching memory. A miss to a cachable address fetches the whole 8-word line as one burst and then returns the requested word. A fetch that cannot use the cache is passed to memory as a single read.

Control inputs set up the cache. They enable the cache, say whether translation is active, give the per-page cachable attribute, and choose the victim policy (pseudo-random or round-robin). A lockdown floor keeps every line below a given index safe from linefills. A one-cycle pulse invalidates every line.

Top module: `icseg_cache`

## Requirements
- R1: After reset `f_rdy` and `m_req` are low and every line is invalid, so the first cachable fetch after enabling takes a linefill.
- R2: A fetch that hits returns the stored word with no memory request. `f_rdy` is a one-cycle pulse that is seen after the third rising edge, counting the edge that accepts the request.
- R3: A cachable miss raises `m_req` once with `m_burst`=1 and `m_addr` equal to the fetch address with bits [4:0] cleared. It takes eight beats for words 0..7 in ascending order. `f_rdy` rises only after the eighth beat, and the line is valid from then on.
- R4: Bits [7:5] select the segment and bits [31:8] form the tag. Lines with the same segment bits but different tags coexist, and fills in one segment leave the other segments alone.
- R5: While `cen`=0 each fetch raises `m_req` once with `m_burst`=0 and `m_addr` equal to the fetch address, and returns `m_rdata`. The cache is not written.
- R6: Lines present before the cache is disabled still hit with their old contents after it is enabled again.
- R7: With `cen`=1, a fetch is cachable when `mmu_on`=0, whatever `cachable` says. When `mmu_on`=1 it is cachable only if `cachable`=1. A non-cachable fetch is a single read even if its line is present.
- R8: A one-cycle `inv` pulse makes every line invalid.
- R9: With `rr_mode`=1, each segment keeps a pointer that starts at index 0 after reset. A fill uses the pointer, raised to `lock_base` if it is below that value. The pointer then moves on by one and wraps from index 63 back to `lock_base`.
- R10: Lines at indices below `lock_base` are never replaced, in either mode. With `rr_mode`=0 the victim is a pseudo-random index at or above `lock_base`.
- R11: Bits [4:2] select the word within a line, and each word of a filled line returns its own memory value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| f_req | input | 1 | Fetch request, held until `f_rdy` |
| f_addr | input | 32 | Fetch byte address |
| f_rdy | output | 1 | One-cycle pulse: `f_data` valid |
| f_data | output | 32 | Returned instruction word |
| m_req | output | 1 | One-cycle memory request pulse |
| m_burst | output | 1 | 1: 8-beat line burst, 0: single read |
| m_addr | output | 32 | Memory request address |
| m_valid | input | 1 | Memory data beat valid |
| m_rdata | input | 32 | Memory data beat |
| cen | input | 1 | Cache enable |
| rr_mode | input | 1 | 1: round-robin victim, 0: pseudo-random |
| mmu_on | input | 1 | Translation active |
| cachable | input | 1 | Per-page cachable attribute |
| lock_base | input | 6 | Lowest index that linefills may replace |
| inv | input | 1 | Invalidate-all pulse |

## Verification
Fetches are run in several patterns: a cold miss followed by every word of the same line, then several tags aliasing one segment next to a neighbouring segment. Together these separate word selection from tag matching and segment decode. The enable, translation and attribute inputs are toggled around lines that are already resident, and memory contents are changed between accesses. This shows whether a result came from a burst, a single read or stored data. A round-robin sequence with a high lockdown floor exposes the exact victim order and the wrap. A long run of pseudo-random fills beside two locked lines shows whether the floor holds.

// File: rtl/icseg_pkg.sv
package icseg_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_HIT,
    S_FILL,
    S_BYP
  } fsm_t;
endpackage

// File: rtl/icseg_tag_store.sv
module icseg_tag_store #(
  parameter int SEGS  = 8,
  parameter int WAYS  = 64,
  parameter int TAG_W = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inv,
  input  logic [$clog2(SEGS)-1:0]  lk_seg,
  input  logic [TAG_W-1:0]         lk_tag,
  output logic                     hit,
  output logic [$clog2(WAYS)-1:0]  hit_way,
  input  logic                     wr_en,
  input  logic [$clog2(SEGS)-1:0]  wr_seg,
  input  logic [$clog2(WAYS)-1:0]  wr_way,
  input  logic [TAG_W-1:0]         wr_tag
);
  localparam int SEG_W = $clog2(SEGS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int LINES = SEGS * WAYS;

  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] vld_q;
  logic [WAYS-1:0]  match;

  // invalidate wins over a same-cycle fill completion
  always_ff @(posedge clk) begin
    if (rst || inv) vld_q <= '0;
    else if (wr_en) vld_q[{wr_seg, wr_way}] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[{wr_seg, wr_way}] <= wr_tag;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    localparam logic [WAY_W-1:0] WI = WAY_W'(w);
    assign match[w] = vld_q[{lk_seg, WI}] && (tag_q[{lk_seg, WI}] == lk_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match[i]) hit_way = WAY_W'(i);
    end
  end

  assign hit = |match;

  // R4
  tag_unique_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));

  logic unused_w;
  assign unused_w = ^SEG_W;
endmodule

// File: rtl/icseg_data_ram.sv
module icseg_data_ram #(
  parameter int DEPTH = 4096,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/icseg_victim.sv
module icseg_victim #(
  parameter int SEGS = 8,
  parameter int WAYS = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rr_mode,
  input  logic [$clog2(WAYS)-1:0]  lock_base,
  input  logic [$clog2(SEGS)-1:0]  seg,
  input  logic                     adv,
  output logic [$clog2(WAYS)-1:0]  victim
);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int LFSR_W = 16;

  logic [LFSR_W-1:0] lfsr_q;
  logic [WAY_W-1:0]  ptr_q [SEGS];
  logic [WAY_W-1:0]  rr_v;
  logic [WAY_W-1:0]  rnd_raw;
  logic [WAY_W-1:0]  rnd_v;

  always_ff @(posedge clk) begin
    if (rst) lfsr_q <= LFSR_W'(1);
    else     lfsr_q <= {lfsr_q[LFSR_W-2:0],
                        lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
  end

  assign rr_v    = (ptr_q[seg] < lock_base) ? lock_base : ptr_q[seg];
  assign rnd_raw = lfsr_q[WAY_W-1:0];
  // OR-ing the floor in keeps the result at or above it
  assign rnd_v   = (rnd_raw < lock_base) ? (rnd_raw | lock_base) : rnd_raw;
  assign victim  = rr_mode ? rr_v : rnd_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SEGS; i++) ptr_q[i] <= '0;
    end else if (adv && rr_mode) begin
      ptr_q[seg] <= (rr_v == WAY_W'(WAYS - 1)) ? lock_base : rr_v + 1'b1;
    end
  end
endmodule

// File: rtl/icseg_cache.sv
module icseg_cache #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SEGS  = 8,
  parameter int WAYS  = 64,
  parameter int WORDS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     f_req,
  input  logic [AW-1:0]            f_addr,
  output logic                     f_rdy,
  output logic [DW-1:0]            f_data,
  output logic                     m_req,
  output logic                     m_burst,
  output logic [AW-1:0]            m_addr,
  input  logic                     m_valid,
  input  logic [DW-1:0]            m_rdata,
  input  logic                     cen,
  input  logic                     rr_mode,
  input  logic                     mmu_on,
  input  logic                     cachable,
  input  logic [$clog2(WAYS)-1:0]  lock_base,
  input  logic                     inv
);
  import icseg_pkg::*;

  localparam int OFF_W = $clog2(DW / 8);
  localparam int WRD_W = $clog2(WORDS);
  localparam int SEG_W = $clog2(SEGS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int LINE_LO = OFF_W + WRD_W;
  localparam int TAG_W = AW - LINE_LO - SEG_W;
  localparam int DEPTH = SEGS * WAYS * WORDS;
  localparam logic [WRD_W-1:0] LAST = WRD_W'(WORDS - 1);

  fsm_t              st;
  logic [AW-1:0]     a_q;
  logic              en_q;
  logic              use_q;
  logic [WAY_W-1:0]  vic_q;
  logic [WRD_W-1:0]  beat_q;
  logic [DW-1:0]     cap_q;

  logic [WRD_W-1:0]  wrd;
  logic [SEG_W-1:0]  seg;
  logic [TAG_W-1:0]  tag;
  logic              hit;
  logic [WAY_W-1:0]  hit_way;
  logic [WAY_W-1:0]  victim;
  logic              adv;
  logic              fill_beat;
  logic              fill_last;
  logic [DW-1:0]     rd_data;

  assign wrd = a_q[OFF_W +: WRD_W];
  assign seg = a_q[LINE_LO +: SEG_W];
  assign tag = a_q[AW-1 -: TAG_W];

  assign adv       = (st == S_LOOK) && use_q && !hit;
  assign fill_beat = (st == S_FILL) && m_valid;
  assign fill_last = fill_beat && (beat_q == LAST);

  icseg_tag_store #(.SEGS(SEGS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk     (clk),
    .rst     (rst),
    .inv     (inv),
    .lk_seg  (seg),
    .lk_tag  (tag),
    .hit     (hit),
    .hit_way (hit_way),
    .wr_en   (fill_last),
    .wr_seg  (seg),
    .wr_way  (vic_q),
    .wr_tag  (tag)
  );

  icseg_data_ram #(.DEPTH(DEPTH), .DW(DW)) u_data (
    .clk   (clk),
    .we    (fill_beat),
    .waddr ({seg, vic_q, beat_q}),
    .wdata (m_rdata),
    .raddr ({seg, hit_way, wrd}),
    .rdata (rd_data)
  );

  icseg_victim #(.SEGS(SEGS), .WAYS(WAYS)) u_vic (
    .clk       (clk),
    .rst       (rst),
    .rr_mode   (rr_mode),
    .lock_base (lock_base),
    .seg       (seg),
    .adv       (adv),
    .victim    (victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      f_rdy   <= 1'b0;
      f_data  <= '0;
      m_req   <= 1'b0;
      m_burst <= 1'b0;
      m_addr  <= '0;
      a_q     <= '0;
      en_q    <= 1'b0;
      use_q   <= 1'b0;
      vic_q   <= '0;
      beat_q  <= '0;
      cap_q   <= '0;
    end else begin
      f_rdy <= 1'b0;
      m_req <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (f_req && !f_rdy) begin
            a_q   <= f_addr;
            en_q  <= cen;
            use_q <= cen && (cachable || !mmu_on);
            st    <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (use_q && hit) begin
            st <= S_HIT;
          end else if (use_q) begin
            vic_q   <= victim;
            beat_q  <= '0;
            m_req   <= 1'b1;
            m_burst <= 1'b1;
            m_addr  <= {a_q[AW-1:LINE_LO], {LINE_LO{1'b0}}};
            st      <= S_FILL;
          end else begin
            m_req   <= 1'b1;
            m_burst <= 1'b0;
            m_addr  <= a_q;
            st      <= S_BYP;
          end
        end
        S_HIT: begin
          f_rdy  <= 1'b1;
          f_data <= rd_data;
          st     <= S_IDLE;
        end
        S_FILL: begin
          if (m_valid) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == wrd) cap_q <= m_rdata;
            if (beat_q == LAST) begin
              f_rdy  <= 1'b1;
              f_data <= (beat_q == wrd) ? m_rdata : cap_q;
              st     <= S_IDLE;
            end
          end
        end
        S_BYP: begin
          if (m_valid) begin
            f_rdy  <= 1'b1;
            f_data <= m_rdata;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    f_rdy |=> !f_rdy);

  // R5
  bypass_single_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && !en_q) |-> !m_burst);

  // R3
  fill_done_chk: assert property (@(posedge clk) disable iff (rst)
    fill_last |=> (f_rdy && st == S_IDLE));

  // R3
  req_rdy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({m_req, f_rdy}));

  // R10
  victim_floor_chk: assert property (@(posedge clk) disable iff (rst)
    adv |=> (vic_q >= $past(lock_base)));
endmodule

// File: tb/tb_icseg_cache.sv
module tb_icseg_cache;
  localparam int CLK_PERIOD = 10;
  localparam int HIT = 0;
  localparam int FILL = 1;
  localparam int SGL = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic        f_req;
  logic [31:0] f_addr;
  logic        f_rdy;
  logic [31:0] f_data;
  logic        m_req;
  logic        m_burst;
  logic [31:0] m_addr;
  logic        m_valid;
  logic [31:0] m_rdata;
  logic        cen;
  logic        rr_mode;
  logic        mmu_on;
  logic        cachable;
  logic [5:0]  lock_base;
  logic        inv;

  int checks = 0;
  int failures = 0;
  int ver = 0;
  int nreq;
  int beats;
  logic        last_burst;
  logic [31:0] last_maddr;
  int snap [logic [31:0]];

  always #(CLK_PERIOD / 2) clk = ~clk;

  icseg_cache dut (
    .clk(clk), .rst(rst), .f_req(f_req), .f_addr(f_addr), .f_rdy(f_rdy),
    .f_data(f_data), .m_req(m_req), .m_burst(m_burst), .m_addr(m_addr),
    .m_valid(m_valid), .m_rdata(m_rdata), .cen(cen), .rr_mode(rr_mode),
    .mmu_on(mmu_on), .cachable(cachable), .lock_base(lock_base), .inv(inv)
  );

  function automatic logic [31:0] memf(input logic [31:0] a, input int v);
    return {a[31:2], 2'b00} ^ (32'(v) * 32'h9E37_79B9) ^ 32'h1357_9BDF;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  // memory model: one request at a time, beats from the next negedge
  initial begin
    logic [31:0] a;
    int n;
    m_valid = 1'b0;
    m_rdata = '0;
    forever begin
      @(negedge clk);
      if (m_req) begin
        a = m_addr;
        n = m_burst ? 8 : 1;
        nreq++;
        last_burst = m_burst;
        last_maddr = m_addr;
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
          m_valid = 1'b1;
          m_rdata = memf(a + 32'(4 * i), ver);
          beats++;
          @(negedge clk);
        end
        m_valid = 1'b0;
      end
    end
  end

  // per-clock comparison: a response only while a fetch is pending
  always @(posedge clk) begin
    #1;
    if (!rst && f_rdy && !f_req) chk(1'b0, "R2", "rdy without request", 32'(f_rdy), 32'd0);
  end

  task automatic fetch(input logic [31:0] a, input int kind, input string rq);
    int cyc;
    logic [31:0] line;
    logic [31:0] exp;
    line = {a[31:5], 5'b0};
    nreq = 0;
    beats = 0;
    @(negedge clk);
    f_req = 1'b1;
    f_addr = a;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!f_rdy && cyc < 300);
    f_req = 1'b0;
    if (cyc >= 300) begin
      chk(1'b0, rq, "fetch timeout", a, 32'd0);
      return;
    end
    if (kind == HIT) begin
      exp = snap.exists(line) ? memf(a, snap[line]) : 32'hDEAD_BEEF;
      chk(nreq == 0, rq, "hit made memory request", 32'(nreq), 32'd0);
      chk(cyc == 3, rq, "hit latency", 32'(cyc), 32'd3);
    end else if (kind == FILL) begin
      exp = memf(a, ver);
      snap[line] = ver;
      chk(nreq == 1 && last_burst, rq, "burst request", 32'(nreq), 32'd1);
      chk(last_maddr == line, rq, "burst address", last_maddr, line);
      chk(beats == 8, rq, "beats before response", 32'(beats), 32'd8);
    end else begin
      exp = memf(a, ver);
      chk(nreq == 1 && !last_burst, rq, "single request", 32'(nreq), 32'd1);
      chk(last_maddr == a, rq, "single address", last_maddr, a);
    end
    chk(f_data == exp, rq, "fetch data", f_data, exp);
  endtask

  task automatic pulse_inv();
    @(negedge clk);
    inv = 1'b1;
    @(negedge clk);
    inv = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] a0;
    rst = 1'b1; f_req = 1'b0; f_addr = '0; cen = 1'b0; rr_mode = 1'b0;
    mmu_on = 1'b0; cachable = 1'b0; lock_base = '0; inv = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset outputs
    chk(!f_rdy, "R1", "f_rdy after reset", 32'(f_rdy), 32'd0);
    chk(!m_req, "R1", "m_req after reset", 32'(m_req), 32'd0);

    a0 = 32'h0000_1048;
    // R5 disabled fetch is a single read and writes nothing
    fetch(a0, SGL, "R5");
    cen = 1'b1;
    // R1 invalid after reset, R7 translation off means cachable
    fetch(a0, FILL, "R1");
    // R11 every word of the line, R2 hit timing
    for (int w = 0; w < 8; w++) fetch({a0[31:5], 3'(w), 2'b00}, HIT, "R11");
    fetch(a0, HIT, "R2");

    // R4 same segment, different tags; neighbouring segment
    fetch(a0 + 32'h100, FILL, "R4");
    fetch(a0 + 32'h200, FILL, "R4");
    fetch(a0 + 32'h20, FILL, "R4");
    fetch(a0, HIT, "R4");
    fetch(a0 + 32'h104, HIT, "R4");
    fetch(a0 + 32'h200, HIT, "R4");

    // R6 disable, change memory, bypass, re-enable, old data
    cen = 1'b0;
    ver++;
    fetch(a0, SGL, "R6");
    fetch(32'h0000_5000, SGL, "R5");
    cen = 1'b1;
    fetch(a0, HIT, "R6");
    fetch(32'h0000_5000, FILL, "R5");

    // R7 attribute with translation on
    mmu_on = 1'b1;
    cachable = 1'b0;
    fetch(32'h0000_20C0, SGL, "R7");
    fetch(a0, SGL, "R7");
    cachable = 1'b1;
    fetch(32'h0000_20C0, FILL, "R7");
    fetch(32'h0000_20C4, HIT, "R7");
    mmu_on = 1'b0;
    cachable = 1'b0;

    // R8 invalidate all
    pulse_inv();
    fetch(a0, FILL, "R8");
    fetch(32'h0000_20C0, FILL, "R8");

    // R9 round-robin in segment 5 with floor 60
    rr_mode = 1'b1;
    lock_base = 6'd60;
    for (int k = 0; k < 5; k++) fetch(32'h0400_00A0 + 32'(k << 8), FILL, "R9");
    fetch(32'h0400_01A0, HIT, "R9");
    fetch(32'h0400_02A0, HIT, "R9");
    fetch(32'h0400_03A0, HIT, "R9");
    fetch(32'h0400_00A0, FILL, "R9");

    // R10 lock two lines in segment 2, then many random fills
    pulse_inv();
    lock_base = 6'd0;
    fetch(32'h0300_0040, FILL, "R10");
    fetch(32'h0300_0140, FILL, "R10");
    lock_base = 6'd2;
    rr_mode = 1'b0;
    for (int k = 2; k < 152; k++) fetch(32'h0300_0040 + 32'(k << 8), FILL, "R10");
    fetch(32'h0300_0044, HIT, "R10");
    fetch(32'h0300_015C, HIT, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule